// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block is the master sequencer for a single-data-rate SDRAM. After reset it holds the clock enable low. It then raises the clock enable and keeps the command bus at NOP for a programmable power-up window. Next it brings the device up with one precharge-all, two auto-refreshes and a mode-register load. Once the mode-register delay has elapsed it reports ready and starts a free-running refresh interval timer.

After init, one arbiter chooses between periodic refresh and user access. A refresh interval expiring while the arbiter is idle starts a refresh at once. Each refresh is a precharge-all, a wait of tRP, an auto-refresh and a wait of tRFC. A user request that is granted holds the grant until the user signals completion. A refresh that falls due during an access is latched. It runs as soon as that access completes, before any further grant. The burst datapath is outside this block: the sequencer only frames the access window.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While rst_ni is low, cke_o is 0, cmd_o is NOP, ready_o is 0 and grant_o is 0.
- R2: From the first clock after reset release, cke_o is 1 and cmd_o is NOP for exactly PWRUP_CYC cycles before the first non-NOP command.
- R3: Command encoding on cmd_o is {cs_n,ras_n,cas_n,we_n}: NOP 4'b0111, PRECHARGE 4'b0010, REFRESH 4'b0001, MODE LOAD 4'b0000. Init issues PRECHARGE with addr_o[10]=1, then REFRESH T_RP cycles later, then REFRESH T_RFC cycles after that, then MODE LOAD T_RFC cycles after that, with addr_o equal to MODE_WORD and ba_o equal to 0.
- R4: ready_o rises exactly T_MRD cycles after the MODE LOAD cycle and stays high until reset.
- R5: Every periodic refresh is a PRECHARGE with addr_o[10]=1, followed T_RP cycles later by a REFRESH. ref_busy_o is high for exactly T_RP+T_RFC cycles, starting with the PRECHARGE cycle.
- R6: While no access is running, consecutive periodic PRECHARGE commands are exactly REF_WRAP+1 cycles apart.
- R7: With ready_o high and no refresh due, req_i high at a clock edge makes grant_o high from the next cycle. grant_o stays high until the edge at which done_i is high, and is low in the cycle after that edge.
- R8: A refresh falling due during an access issues no command while grant_o is high. Its PRECHARGE appears in the cycle right after the done_i edge, with grant_o low. Two periodic PRECHARGEs are never more than REF_WRAP+1 plus the longest access length apart.
- R9: When a refresh falls due at the same edge that sees req_i in idle, the refresh goes first. grant_o first rises T_RP+T_RFC+1 cycles after that PRECHARGE.
- R10: grant_o stays low while ready_o is low, whatever req_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (100 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | User access request |
| done_i | input | 1 | User access complete, sampled while granted |
| cke_o | output | 1 | SDRAM clock enable |
| cmd_o | output | 4 | {cs_n,ras_n,cas_n,we_n} command |
| addr_o | output | ADDR_W | SDRAM address bus |
| ba_o | output | BA_W | SDRAM bank address |
| ready_o | output | 1 | Initialisation complete |
| ref_busy_o | output | 1 | Periodic refresh in progress |
| grant_o | output | 1 | Access window open |

## Verification
The refresh interval flag can coincide with two other events: a fresh user request, or the completion of an access in flight. The bench knows the periodic refresh cadence from the last precharge it saw. It raises req_i exactly in the cycle where the next interval expires. It then expects the precharge in the following cycle and the grant only T_RP+T_RFC+1 cycles later. In a second run it opens an access that spans an expiry and closes it with done_i. It then expects no command during the access, and the precharge in the very next cycle with the grant already gone.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    E_IDLE,
    E_PRE,
    E_WRP,
    E_REF,
    E_WRFC
  } eng_e;

  typedef enum logic [2:0] {
    A_PWR,
    A_INIT1,
    A_INIT2,
    A_MRS,
    A_MRD,
    A_IDLE,
    A_REF,
    A_ACC
  } arb_e;

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int unsigned REF_WRAP = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(REF_WRAP + 1);
  localparam logic [CW-1:0] WRAP_V = CW'(REF_WRAP);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (en_i) begin
      if (cnt_q == WRAP_V) begin
        cnt_q  <= '0;
        flag_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        flag_o <= 1'b0;
      end
    end
  end

  p_flag_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |=> !flag_o);

endmodule

// File: rtl/sdram_ref_engine.sv
module sdram_ref_engine
  import sdram_seq_pkg::*;
#(
  parameter int unsigned T_RP  = 2,
  parameter int unsigned T_RFC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pre_i,
  output cmd_e cmd_o,
  output logic a10_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned TMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int unsigned CW = $clog2(TMAX + 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(T_RP - 2);
  localparam logic [CW-1:0] RFC_LAST = CW'(T_RFC - 2);

  eng_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  eng_e launch;

  assign launch = pre_i ? E_PRE : E_REF;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      E_IDLE: if (start_i) st_d = launch;
      E_PRE: begin
        st_d  = E_WRP;
        cnt_d = '0;
      end
      E_WRP:
        if (cnt_q == RP_LAST) st_d = E_REF;
        else cnt_d = cnt_q + 1'b1;
      E_REF: begin
        st_d  = E_WRFC;
        cnt_d = '0;
      end
      E_WRFC:
        if (cnt_q == RFC_LAST) st_d = start_i ? launch : E_IDLE;
        else cnt_d = cnt_q + 1'b1;
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= E_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign cmd_o  = (st_q == E_PRE) ? CMD_PRE : (st_q == E_REF) ? CMD_REF : CMD_NOP;
  assign a10_o  = (st_q == E_PRE);
  assign busy_o = (st_q != E_IDLE);
  assign done_o = (st_q == E_WRFC) && (cnt_q == RFC_LAST);

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 10000,
  parameter int unsigned REF_WRAP  = 780,
  parameter int unsigned T_RP      = 2,
  parameter int unsigned T_RFC     = 7,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned BA_W      = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 13'h0032
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              done_i,
  output logic              cke_o,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              ready_o,
  output logic              ref_busy_o,
  output logic              grant_o
);
  localparam int unsigned CMAX = (PWRUP_CYC > T_MRD) ? PWRUP_CYC : T_MRD;
  localparam int unsigned CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] PWR_LAST = CW'(PWRUP_CYC - 1);
  localparam logic [CW-1:0] MRD_LAST = CW'(T_MRD - 2);
  localparam int unsigned A10 = 10;

  arb_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cke_q, rdy_q, pend_q;
  logic ref_flag, ref_due, pend_clr;
  logic eng_start, eng_pre, eng_a10, eng_busy, eng_done;
  cmd_e eng_cmd;

  sdram_ref_timer #(.REF_WRAP(REF_WRAP)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rdy_q),
    .flag_o (ref_flag)
  );

  sdram_ref_engine #(.T_RP(T_RP), .T_RFC(T_RFC)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .pre_i   (eng_pre),
    .cmd_o   (eng_cmd),
    .a10_o   (eng_a10),
    .busy_o  (eng_busy),
    .done_o  (eng_done)
  );

  assign ref_due = pend_q | ref_flag;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    eng_start = 1'b0;
    eng_pre   = 1'b1;
    pend_clr  = 1'b0;
    unique case (st_q)
      A_PWR:
        if (cke_q) begin
          if (cnt_q == PWR_LAST) begin
            cnt_d     = '0;
            eng_start = 1'b1;
            st_d      = A_INIT1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      A_INIT1:
        if (eng_done) begin
          eng_start = 1'b1;
          eng_pre   = 1'b0;  // second refresh needs no precharge
          st_d      = A_INIT2;
        end
      A_INIT2: if (eng_done) st_d = A_MRS;
      A_MRS: begin
        cnt_d = '0;
        st_d  = A_MRD;
      end
      A_MRD:
        if (cnt_q == MRD_LAST) st_d = A_IDLE;
        else cnt_d = cnt_q + 1'b1;
      A_IDLE:
        if (ref_due) begin
          eng_start = 1'b1;
          pend_clr  = 1'b1;
          st_d      = A_REF;
        end else if (req_i) begin
          st_d = A_ACC;
        end
      A_ACC:
        if (done_i) begin
          if (ref_due) begin
            eng_start = 1'b1;
            pend_clr  = 1'b1;
            st_d      = A_REF;
          end else begin
            st_d = A_IDLE;
          end
        end
      A_REF: if (eng_done) st_d = A_IDLE;
      default: st_d = A_PWR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= A_PWR;
      cnt_q  <= '0;
      cke_q  <= 1'b0;
      rdy_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      cke_q  <= 1'b1;
      if (st_q == A_MRD && cnt_q == MRD_LAST) rdy_q <= 1'b1;
      pend_q <= pend_clr ? 1'b0 : (pend_q | ref_flag);
    end
  end

  always_comb begin
    addr_o = '0;
    if (st_q == A_MRS) addr_o = MODE_WORD;
    else addr_o[A10] = eng_a10;
  end

  assign cmd_o      = (st_q == A_MRS) ? CMD_MRS : eng_cmd;
  assign ba_o       = '0;
  assign cke_o      = cke_q;
  assign ready_o    = rdy_q;
  assign ref_busy_o = (st_q == A_REF);
  assign grant_o    = (st_q == A_ACC);

  p_cke_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !cke_o);

  p_start_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start |-> (!eng_busy || eng_done));

  p_ready_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_pre_a10_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |-> addr_o[A10]);

  p_pend_served_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && done_i && ref_due) |=> (ref_busy_o && cmd_o == CMD_PRE));

  p_no_grant_due_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> !$past(ref_due));

  p_grant_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> ready_o);

endmodule

// File: tb/sdram_seq_ctrl_tb.sv
module sdram_seq_ctrl_tb;
  localparam int PWR   = 40;
  localparam int WRAP  = 780;
  localparam int TRP   = 2;
  localparam int TRFC  = 7;
  localparam int TMRD  = 2;
  localparam int LMAX  = 40;
  localparam logic [12:0] MODE = 13'h0032;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  // expected init sequence: command and gap from previous event (reset release first)
  localparam logic [3:0] EXP_CMD [4] = '{PRE, REF, REF, MRS};
  localparam int         EXP_GAP [4] = '{PWR + 1, TRP, TRFC, TRFC};

  logic clk = 1'b0;
  logic rst_ni, req_i, done_i;
  logic cke_o, ready_o, ref_busy_o, grant_o;
  logic [3:0] cmd_o;
  logic [12:0] addr_o;
  logic [1:0] ba_o;

  always #10 clk = ~clk;

  sdram_seq_ctrl #(
    .PWRUP_CYC(PWR), .REF_WRAP(WRAP), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
    .ADDR_W(13), .BA_W(2), .MODE_WORD(MODE)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .done_i(done_i),
    .cke_o(cke_o), .cmd_o(cmd_o), .addr_o(addr_o), .ba_o(ba_o),
    .ready_o(ready_o), .ref_busy_o(ref_busy_o), .grant_o(grant_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  int pwr_bad = 0, early_grant = 0, init_n = 0;
  int last_pre = -1, prev_pre = -1, pre_cnt = 0, busy_run = 0, ready_cyc = -1;
  logic [3:0]  log_cmd  [4];
  int          log_cyc  [4];
  logic [12:0] log_addr [4];
  logic [1:0]  log_ba   [4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (rst_ni) begin
      if (!ready_o) begin
        if (cyc <= PWR && (cke_o !== 1'b1 || cmd_o !== NOP)) pwr_bad++;
        if (grant_o) early_grant++;
        if (cmd_o !== NOP && init_n < 4) begin
          log_cmd[init_n]  = cmd_o;
          log_cyc[init_n]  = cyc;
          log_addr[init_n] = addr_o;
          log_ba[init_n]   = ba_o;
          init_n++;
        end
      end else begin
        if (cmd_o == PRE) begin
          if (last_pre >= 0)
            chk(cyc - last_pre <= WRAP + 1 + LMAX, "R8 refresh gap bound", cyc - last_pre, WRAP + 1 + LMAX);
          chk(addr_o[10] == 1'b1, "R5 precharge-all A10", int'(addr_o[10]), 1);
          prev_pre = last_pre;
          last_pre = cyc;
          pre_cnt++;
        end
        if (cmd_o == REF)
          chk(cyc - last_pre == TRP, "R5 refresh after precharge", cyc - last_pre, TRP);
      end
      if (ref_busy_o) busy_run++;
      else if (busy_run > 0) begin
        chk(busy_run == TRP + TRFC, "R5 busy length", busy_run, TRP + TRFC);
        busy_run = 0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, n;
    rst_ni = 1'b0; req_i = 1'b0; done_i = 1'b0;
    repeat (3) tick();
    chk(cke_o == 1'b0, "R1 cke in reset", int'(cke_o), 0);
    chk(cmd_o == NOP, "R1 cmd in reset", int'(cmd_o), int'(NOP));
    chk(ready_o == 1'b0, "R1 ready in reset", int'(ready_o), 0);
    chk(grant_o == 1'b0, "R1 grant in reset", int'(grant_o), 0);

    rst_ni = 1'b1;
    cyc = 0;
    req_i = 1'b1;  // R10: held through init
    do tick(); while (!ready_o && cyc < PWR + 200);
    ready_cyc = cyc;

    chk(pwr_bad == 0, "R2 NOP with CKE high window", pwr_bad, 0);
    chk(init_n == 4, "R3 init command count", init_n, 4);
    for (int i = 0; i < 4; i++) begin
      chk(log_cmd[i] == EXP_CMD[i], "R3 init command order", int'(log_cmd[i]), int'(EXP_CMD[i]));
      chk(log_cyc[i] - ((i == 0) ? 0 : log_cyc[i-1]) == EXP_GAP[i], "R3 init spacing",
          log_cyc[i] - ((i == 0) ? 0 : log_cyc[i-1]), EXP_GAP[i]);
    end
    chk(log_addr[0][10] == 1'b1, "R3 init precharge A10", int'(log_addr[0][10]), 1);
    chk(log_addr[3] == MODE, "R3 mode word", int'(log_addr[3]), int'(MODE));
    chk(log_ba[3] == 2'd0, "R3 mode bank", int'(log_ba[3]), 0);
    chk(ready_cyc - log_cyc[3] == TMRD, "R4 ready after tMRD", ready_cyc - log_cyc[3], TMRD);
    chk(early_grant == 0, "R10 no grant before ready", early_grant, 0);

    tick();
    chk(grant_o == 1'b1, "R7 grant after held request", int'(grant_o), 1);
    req_i = 1'b0;
    repeat (4) tick();
    chk(grant_o == 1'b1, "R7 grant held", int'(grant_o), 1);
    done_i = 1'b1;
    tick();
    done_i = 1'b0;
    chk(grant_o == 1'b0, "R7 grant drops after done", int'(grant_o), 0);
    chk(ready_o == 1'b1, "R4 ready stays high", int'(ready_o), 1);

    n = 0;
    while (pre_cnt < 2 && n < 3000) begin tick(); n++; end
    chk(last_pre - prev_pre == WRAP + 1, "R6 idle refresh period", last_pre - prev_pre, WRAP + 1);

    // R9: request lands on the refresh-due edge
    p = last_pre;
    while (cyc < p + WRAP) tick();
    req_i = 1'b1;
    tick();
    chk(cmd_o == PRE, "R9 refresh wins tie", int'(cmd_o), int'(PRE));
    chk(grant_o == 1'b0, "R9 no grant at tie", int'(grant_o), 0);
    p = cyc;
    n = 0;
    while (!grant_o && n < 50) begin tick(); n++; end
    chk(cyc - p == TRP + TRFC + 1, "R9 grant after refresh", cyc - p, TRP + TRFC + 1);
    req_i = 1'b0;
    tick();
    done_i = 1'b1;
    tick();
    done_i = 1'b0;

    // R8: access spans the refresh-due point
    p = last_pre;
    while (cyc < p + WRAP - 20) tick();
    req_i = 1'b1;
    tick();
    chk(grant_o == 1'b1, "R7 grant in idle", int'(grant_o), 1);
    req_i = 1'b0;
    while (cyc < p + WRAP + 10) tick();
    chk(last_pre == p, "R8 no refresh during access", last_pre, p);
    chk(grant_o == 1'b1, "R8 access kept over due refresh", int'(grant_o), 1);
    done_i = 1'b1;
    tick();
    done_i = 1'b0;
    chk(cmd_o == PRE, "R8 pending refresh after access", int'(cmd_o), int'(PRE));
    chk(grant_o == 1'b0, "R8 grant closed at refresh", int'(grant_o), 0);
    chk(ref_busy_o == 1'b1, "R8 busy at pending refresh", int'(ref_busy_o), 1);
    repeat (20) tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule